// File: doc/BRIEF.md
# Two-Port Shared Word Memory with Collision Arbitration

This block is a 4096 x 16 storage array shared by two fully independent ports, called left (A) and right (B). Each port has an enable, a write/read select, an output enable and a select for each of its two byte lanes. Reads and writes are synchronous to one clock. Ports working on different words never interfere, and both ports may read the same word in the same cycle.

On every cycle the block compares the two enabled addresses. When both point at the same word, exactly one port is marked as the loser through its active-low busy flag. That port's write is suppressed, but its read still completes. The port that already held the word keeps it. If both ports arrive in the same cycle, the left port wins. The loser stays the same for as long as the match lasts.

A mode input selects between master and slave. A master makes the busy decision itself and drives it out. A slave drives its busy outputs inactive and takes busy inputs from a master, using them only to block writes. This lets several instances act as one wider word that has a single arbiter.

Top module: `twin_port_mem`

## Requirements
- R1: A write (enable=1, write select=1) stores only the byte lanes whose selects are high: the lower select updates bits 7:0 and the upper select updates bits 15:8. The other lane keeps its old value.
- R2: A read (enable=1, write select=0) at a clock edge loads the addressed word into the port's read register. The read register changes only on reads. The data output shows this register while output enable is high and shows zero while output enable is low.
- R3: Two writes to different addresses in the same cycle both complete, each through its own port.
- R4: Both ports may read the same address in the same cycle, and both receive the stored word.
- R5: In master mode, when both ports are enabled with equal addresses, exactly one busy flag is driven low (0 = busy) in that same cycle. Both flags are never low together.
- R6: When the match begins, a port counts as already holding the word if it was enabled at that same address on the previous clock edge. If exactly one port held the word, the other port is the loser. While the match continues, the loser does not change.
- R7: If both ports begin the match in the same cycle, or neither port held the word, the right port is the loser. The loser's write is dropped and the winner's write is stored.
- R8: In any cycle where the enabled addresses do not match, both busy flags are high.
- R9: A port with enable low performs no access and causes no busy flag on either port.
- R10: In slave mode, both busy outputs stay high. A low busy input blocks that port's write, and reads still complete.
- R11: After reset, both read registers are zero and both busy flags are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| isMaster | input | 1 | 1 = master (drives busy), 0 = slave (takes busy in) |
| aEn | input | 1 | Left port enable |
| aWr | input | 1 | Left port: 1 = write, 0 = read |
| aOe | input | 1 | Left port output enable |
| aUpper | input | 1 | Left port upper byte select |
| aLower | input | 1 | Left port lower byte select |
| aAddr | input | 12 | Left port word address |
| aWdata | input | 16 | Left port write data |
| aRdata | output | 16 | Left port read data |
| aBusyN | output | 1 | Left port busy flag, active low (master) |
| aBusyInN | input | 1 | Left port busy input, active low (slave) |
| bEn | input | 1 | Right port enable |
| bWr | input | 1 | Right port: 1 = write, 0 = read |
| bOe | input | 1 | Right port output enable |
| bUpper | input | 1 | Right port upper byte select |
| bLower | input | 1 | Right port lower byte select |
| bAddr | input | 12 | Right port word address |
| bWdata | input | 16 | Right port write data |
| bRdata | output | 16 | Right port read data |
| bBusyN | output | 1 | Right port busy flag, active low (master) |
| bBusyInN | input | 1 | Right port busy input, active low (slave) |

## Verification
The bench targets a simultaneous same-word write. A design with a reversed tie rule would store the right port's data and flag the left port. A late arrival at a word already held is also tested; a design that ignored history would flag the wrong port and let the newcomer overwrite the data. The bench moves a port away after a collision, and a design that held busy too long would show a stale busy flag. It also disables one port at a matching address, and a design that ignored enable would raise busy for no reason. In slave mode, a design that still ran its own arbiter would drive busy out or let a blocked write through.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  typedef enum logic [1:0] {
    LOSE_NONE  = 2'd0,
    LOSE_LEFT  = 2'd1,
    LOSE_RIGHT = 2'd2
  } loser_e;

  typedef struct packed {
    logic aWrite;
    logic aRead;
    logic bWrite;
    logic bRead;
  } dpm_strobe_t;
endpackage

// File: rtl/dpm_ctrl.sv
module dpm_ctrl
  import dpm_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              isMaster,
  input  logic              aEn,
  input  logic              aWr,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic              aBusyInN,
  input  logic              bEn,
  input  logic              bWr,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic              bBusyInN,
  output dpm_strobe_t       strobe,
  output logic              aBusyN,
  output logic              bBusyN
);
  logic              aEnQ, bEnQ, matchQ;
  logic [ADDR_W-1:0] aAddrQ, bAddrQ;
  loser_e            loserQ, curLoser, freshLoser;
  logic              match, aHeld, bHeld, aBlock, bBlock;

  assign match = aEn && bEn && (aAddr == bAddr);
  assign aHeld = aEnQ && (aAddrQ == aAddr);
  assign bHeld = bEnQ && (bAddrQ == bAddr);

  // Newcomer loses; tie or no holder: right port loses
  assign freshLoser = (bHeld && !aHeld) ? LOSE_LEFT : LOSE_RIGHT;

  always_comb begin
    if (!match)      curLoser = LOSE_NONE;
    else if (matchQ) curLoser = loserQ;
    else             curLoser = freshLoser;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aEnQ   <= 1'b0;
      bEnQ   <= 1'b0;
      aAddrQ <= '0;
      bAddrQ <= '0;
      matchQ <= 1'b0;
      loserQ <= LOSE_NONE;
    end else begin
      aEnQ   <= aEn;
      bEnQ   <= bEn;
      aAddrQ <= aAddr;
      bAddrQ <= bAddr;
      matchQ <= match;
      loserQ <= curLoser;
    end
  end

  assign aBlock = isMaster ? (curLoser == LOSE_LEFT)  : !aBusyInN;
  assign bBlock = isMaster ? (curLoser == LOSE_RIGHT) : !bBusyInN;

  assign strobe.aWrite = aEn && aWr && !aBlock;
  assign strobe.aRead  = aEn && !aWr;
  assign strobe.bWrite = bEn && bWr && !bBlock;
  assign strobe.bRead  = bEn && !bWr;

  assign aBusyN = !(isMaster && (curLoser == LOSE_LEFT));
  assign bBusyN = !(isMaster && (curLoser == LOSE_RIGHT));
endmodule

// File: rtl/dpm_data.sv
module dpm_data
  import dpm_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpm_strobe_t       strobe,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [DATA_W-1:0] aWdata,
  input  logic [1:0]        aLanes,
  input  logic              aOe,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] bWdata,
  input  logic [1:0]        bLanes,
  input  logic              bOe,
  output logic [DATA_W-1:0] aRdata,
  output logic [DATA_W-1:0] bRdata
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LANES  = 2;
  localparam int LANE_W = DATA_W / LANES;

  logic [DATA_W-1:0] aRdQ, bRdQ;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] rdA, rdB;

    always_ff @(posedge clk) begin
      if (strobe.aWrite && aLanes[g]) laneMem[aAddr] <= aWdata[g*LANE_W +: LANE_W];
      if (strobe.bWrite && bLanes[g]) laneMem[bAddr] <= bWdata[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rdA <= '0;
        rdB <= '0;
      end else begin
        if (strobe.aRead) rdA <= laneMem[aAddr];
        if (strobe.bRead) rdB <= laneMem[bAddr];
      end
    end

    assign aRdQ[g*LANE_W +: LANE_W] = rdA;
    assign bRdQ[g*LANE_W +: LANE_W] = rdB;
  end

  assign aRdata = aOe ? aRdQ : '0;
  assign bRdata = bOe ? bRdQ : '0;
endmodule

// File: rtl/twin_port_mem.sv
module twin_port_mem
  import dpm_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              isMaster,
  input  logic              aEn,
  input  logic              aWr,
  input  logic              aOe,
  input  logic              aUpper,
  input  logic              aLower,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [DATA_W-1:0] aWdata,
  output logic [DATA_W-1:0] aRdata,
  output logic              aBusyN,
  input  logic              aBusyInN,
  input  logic              bEn,
  input  logic              bWr,
  input  logic              bOe,
  input  logic              bUpper,
  input  logic              bLower,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] bWdata,
  output logic [DATA_W-1:0] bRdata,
  output logic              bBusyN,
  input  logic              bBusyInN
);
  dpm_strobe_t strobe;

  dpm_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .isMaster(isMaster),
    .aEn(aEn), .aWr(aWr), .aAddr(aAddr), .aBusyInN(aBusyInN),
    .bEn(bEn), .bWr(bWr), .bAddr(bAddr), .bBusyInN(bBusyInN),
    .strobe(strobe), .aBusyN(aBusyN), .bBusyN(bBusyN)
  );

  dpm_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .aAddr(aAddr), .aWdata(aWdata), .aLanes({aUpper, aLower}), .aOe(aOe),
    .bAddr(bAddr), .bWdata(bWdata), .bLanes({bUpper, bLower}), .bOe(bOe),
    .aRdata(aRdata), .bRdata(bRdata)
  );
endmodule

// File: rtl/twin_port_mem_chk.sv
module twin_port_mem_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              isMaster,
  input logic              aEn,
  input logic              bEn,
  input logic              aOe,
  input logic              bOe,
  input logic [ADDR_W-1:0] aAddr,
  input logic [ADDR_W-1:0] bAddr,
  input logic [DATA_W-1:0] aRdata,
  input logic [DATA_W-1:0] bRdata,
  input logic              aBusyN,
  input logic              bBusyN
);
  logic sameWord;
  assign sameWord = aEn && bEn && (aAddr == bAddr);

  // R5
  never_both_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!aBusyN && !bBusyN));

  // R5
  collision_flags_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sameWord && isMaster) |-> (aBusyN != bBusyN));

  // R8
  no_match_no_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sameWord |-> (aBusyN && bBusyN));

  // R9
  idle_port_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!aEn || !bEn) |-> (aBusyN && bBusyN));

  // R6
  loser_sticks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sameWord && $past(sameWord) && isMaster && $past(isMaster))
      |-> ($stable(aBusyN) && $stable(bBusyN)));

  // R10
  slave_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !isMaster |-> (aBusyN && bBusyN));

  // R2
  oe_gates_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((!aOe -> aRdata == '0) && (!bOe -> bRdata == '0)));
endmodule

bind twin_port_mem twin_port_mem_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (.*);

// File: tb/sim_twin_port_mem.sv
module sim_twin_port_mem;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic isMaster = 1'b1;
  logic aEn = 0, aWr = 0, aOe = 1, aUp = 0, aLo = 0, aBusyInN = 1;
  logic bEn = 0, bWr = 0, bOe = 1, bUp = 0, bLo = 0, bBusyInN = 1;
  logic [11:0] aAddr = '0, bAddr = '0;
  logic [15:0] aWd = '0, bWd = '0;
  logic [15:0] aRdata, bRdata;
  logic aBusyN, bBusyN;

  int errors = 0, checks = 0;
  string curReq = "R11";
  bit done = 0;

  always #5 clk = ~clk;

  twin_port_mem u0 (
    .clk(clk), .rstN(rstN), .isMaster(isMaster),
    .aEn(aEn), .aWr(aWr), .aOe(aOe), .aUpper(aUp), .aLower(aLo),
    .aAddr(aAddr), .aWdata(aWd), .aRdata(aRdata), .aBusyN(aBusyN), .aBusyInN(aBusyInN),
    .bEn(bEn), .bWr(bWr), .bOe(bOe), .bUpper(bUp), .bLower(bLo),
    .bAddr(bAddr), .bWdata(bWd), .bRdata(bRdata), .bBusyN(bBusyN), .bBusyInN(bBusyInN)
  );

  // Reference model state
  logic [15:0] mdl [0:4095];
  logic [15:0] mRdA = '0, mRdB = '0;
  bit pAEn = 0, pBEn = 0, pMatch = 0;
  logic [11:0] pAAddr = '0, pBAddr = '0;
  int pLoser = 0; // 0 none, 1 left, 2 right

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", curReq, what, act, exp);
    end
  endtask

  task automatic cyc();
    bit match, aH, bH, blkA, blkB;
    int los;
    #1;
    match = aEn && bEn && (aAddr == bAddr);
    if (!match) los = 0;
    else if (pMatch) los = pLoser;
    else begin
      aH = pAEn && (pAAddr == aAddr);
      bH = pBEn && (pBAddr == bAddr);
      los = (bH && !aH) ? 1 : 2;
    end
    chk("aBusyN", {15'd0, aBusyN}, {15'd0, !(isMaster && los == 1)});
    chk("bBusyN", {15'd0, bBusyN}, {15'd0, !(isMaster && los == 2)});
    blkA = isMaster ? (los == 1) : !aBusyInN;
    blkB = isMaster ? (los == 2) : !bBusyInN;
    @(posedge clk);
    if (aEn && !aWr) mRdA = mdl[aAddr];
    if (bEn && !bWr) mRdB = mdl[bAddr];
    if (aEn && aWr && !blkA) begin
      if (aLo) mdl[aAddr][7:0]  = aWd[7:0];
      if (aUp) mdl[aAddr][15:8] = aWd[15:8];
    end
    if (bEn && bWr && !blkB) begin
      if (bLo) mdl[bAddr][7:0]  = bWd[7:0];
      if (bUp) mdl[bAddr][15:8] = bWd[15:8];
    end
    pAEn = aEn; pBEn = bEn; pAAddr = aAddr; pBAddr = bAddr;
    pMatch = match; pLoser = los;
    @(negedge clk);
    chk("aRdata", aRdata, aOe ? mRdA : 16'h0);
    chk("bRdata", bRdata, bOe ? mRdB : 16'h0);
  endtask

  task automatic setA(input logic en, input logic wr, input logic [11:0] ad,
                      input logic [15:0] wd, input logic [1:0] lanes);
    aEn = en; aWr = wr; aAddr = ad; aWd = wd; {aUp, aLo} = lanes;
  endtask

  task automatic setB(input logic en, input logic wr, input logic [11:0] ad,
                      input logic [15:0] wd, input logic [1:0] lanes);
    bEn = en; bWr = wr; bAddr = ad; bWd = wd; {bUp, bLo} = lanes;
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("rst aRdata", aRdata, 16'h0);
    chk("rst bRdata", bRdata, 16'h0);
    chk("rst busy", {14'd0, aBusyN, bBusyN}, 16'h3);
    rstN = 1'b1;
    cyc();

    // R3: independent writes to different words
    curReq = "R3";
    setA(1, 1, 12'd5, 16'h1234, 2'b11); setB(1, 1, 12'd6, 16'hABCD, 2'b11); cyc();
    setA(1, 1, 12'd20, 16'h2020, 2'b11); setB(1, 1, 12'd30, 16'h3030, 2'b11); cyc();
    setA(1, 1, 12'd40, 16'h0101, 2'b11); setB(1, 1, 12'd41, 16'h0202, 2'b11); cyc();
    setA(1, 0, 12'd6, 16'h0, 2'b00); setB(1, 0, 12'd5, 16'h0, 2'b00); cyc();

    // R1: byte lanes
    curReq = "R1";
    setA(1, 1, 12'd5, 16'hFF99, 2'b10); setB(1, 1, 12'd6, 16'h77EE, 2'b01); cyc();
    setA(1, 0, 12'd5, 16'h0, 2'b00); setB(1, 0, 12'd6, 16'h0, 2'b00); cyc();

    // R2: read register holds, output enable gates
    curReq = "R2";
    setA(0, 0, 12'd0, 16'h0, 2'b00); setB(1, 1, 12'd7, 16'h5A5A, 2'b11); aOe = 0; cyc();
    aOe = 1; setB(0, 0, 12'd0, 16'h0, 2'b00); cyc();

    // R7: tie on write, left wins
    curReq = "R7";
    setA(1, 1, 12'd10, 16'h1111, 2'b11); setB(1, 1, 12'd10, 16'h2222, 2'b11); cyc();
    setA(1, 0, 12'd10, 16'h0, 2'b00); setB(0, 0, 12'd0, 16'h0, 2'b00); cyc();

    // R6: holder keeps word, newcomer busy and blocked
    curReq = "R6";
    setA(1, 0, 12'd20, 16'h0, 2'b00); setB(0, 0, 12'd0, 16'h0, 2'b00); cyc();
    setB(1, 1, 12'd20, 16'hDEAD, 2'b11); cyc();
    cyc();
    curReq = "R8";
    setB(1, 0, 12'd30, 16'h0, 2'b00); cyc();
    curReq = "R6";
    setA(1, 1, 12'd30, 16'hBEEF, 2'b11); cyc();
    cyc();
    curReq = "R8";
    setA(1, 0, 12'd20, 16'h0, 2'b00); setB(1, 0, 12'd31, 16'h0, 2'b00); cyc();
    setB(1, 0, 12'd30, 16'h0, 2'b00); cyc();

    // R9: disabled port at same address
    curReq = "R9";
    setA(0, 1, 12'd7, 16'h9999, 2'b11); setB(1, 1, 12'd7, 16'h4444, 2'b11); cyc();
    setA(1, 0, 12'd7, 16'h0, 2'b00); setB(0, 0, 12'd7, 16'h0, 2'b00); cyc();

    // R4: shared read
    curReq = "R4";
    setA(1, 0, 12'd5, 16'h0, 2'b00); setB(1, 0, 12'd5, 16'h0, 2'b00); cyc();
    cyc();

    // R10: slave mode
    curReq = "R10";
    setA(0, 0, 12'd0, 16'h0, 2'b00); setB(0, 0, 12'd0, 16'h0, 2'b00); cyc();
    isMaster = 0; aBusyInN = 0;
    setA(1, 1, 12'd40, 16'h5555, 2'b11); setB(1, 1, 12'd41, 16'h6666, 2'b11); cyc();
    setA(1, 0, 12'd40, 16'h0, 2'b00); setB(1, 0, 12'd41, 16'h0, 2'b00); cyc();
    aBusyInN = 1;
    setA(1, 1, 12'd41, 16'h7777, 2'b11); setB(1, 1, 12'd41, 16'h8888, 2'b00); cyc();
    setA(1, 0, 12'd41, 16'h0, 2'b00); setB(0, 0, 12'd0, 16'h0, 2'b00); cyc();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule